// File: doc/BRIEF.md
# Memory-Device Boundary-Scan Test Port

This block is the serial test port of a memory device. It contains a sixteen-state controller that advances on the rising edge of the test clock under the mode-select input. Through that controller the port reaches a 3-bit instruction register and one of three data registers: a 1-bit pass-through stage, a 32-bit identification word and a 63-cell boundary chain.

The boundary chain loads its cells in parallel from a 63-bit pin-sample bus. Its shifted contents move to a held output bus on Update-DR. Two plain control pins tell the memory what the current instruction wants. One puts the memory's data outputs into high impedance. The other makes the pads drive the held boundary data.

The serial output changes only on the falling edge of the test clock. It is flagged as driven only while a register is being shifted. The port is serial test access driven by an external controller, so it has no handshake: every rising edge of the clock is one transfer.

Top module: `mem_tap_ctrl`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`. The controller follows the standard sixteen-state test-port graph, and the selected register shifts one place per rising edge spent in a shift state.
- R2: The instruction register is 3 bits wide. Capture-IR loads 3'b001 into its shift stage. The least significant bit leaves on `tdo` first, and the first bit entering from `tdi` ends up as bit 0. The new instruction takes effect on the falling edge during Update-IR.
- R3: Asynchronous reset (`trst_n` low) and the Test-Logic-Reset state both set the instruction to IDCODE (3'b001). Five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R4: IDCODE (3'b001) selects the 32-bit register. Capture-DR loads parameter `ID_CODE` into it, and the word leaves least significant bit first.
- R5: BYPASS (3'b111) and the reserved codes 3'b011, 3'b101 and 3'b110 select the 1-bit register. It captures 0, so `tdi` reappears on `tdo` one shift later. The reserved codes assert neither `dq_hiz` nor `extest_drive`.
- R6: SAMPLE (3'b100) selects the 63-bit chain. Capture-DR loads `pin_sample` into it, with bit 0 leaving first. Neither `dq_hiz` nor `extest_drive` is asserted.
- R7: SAMPLE-Z (3'b010) selects and captures the chain as SAMPLE does. `dq_hiz` is high for exactly as long as it is the current instruction.
- R8: EXTEST (3'b000) selects and captures the chain. `extest_drive` is high for exactly as long as it is the current instruction.
- R9: On the falling edge during Update-DR, with a chain instruction current (EXTEST, SAMPLE-Z or SAMPLE), `bsr_out` takes the shifted chain contents. At all other times it holds its value, and reset clears it to 0.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_sample | input | 63 | Parallel values seen at the boundary cells |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| bsr_out | output | 63 | Held boundary data for the pads |
| dq_hiz | output | 1 | Place the memory data outputs in high impedance |
| extest_drive | output | 1 | Drive the pads from `bsr_out` |

## Verification
A state change, a capture or a shift happens on the rising edge on which `tms`/`tdi` are presented. Its effect on `tdo`, `tdo_en`, the instruction-driven pins and `bsr_out` becomes visible at the falling edge that follows, half a period later. The bench therefore drives inputs just after a falling edge and advances its reference model at the rising edge. It updates the model's falling-edge effects at the falling edge and compares every output a short time after that falling edge, on every clock. Serial readouts are collected just before the rising edge that shifts the next bit out, so each bit is read while it is stable.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int          IR_W      = 3;
  localparam logic [2:0]  OP_EXTEST = 3'b000;
  localparam logic [2:0]  OP_IDCODE = 3'b001;
  localparam logic [2:0]  OP_SAMPZ  = 3'b010;
  localparam logic [2:0]  OP_SAMPLE = 3'b100;
  localparam logic [2:0]  OP_BYPASS = 3'b111;
  localparam logic [2:0]  IR_CAPTURE_PAT = 3'b001;

  function automatic logic op_uses_chain(input logic [2:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPZ) || (op == OP_SAMPLE);
  endfunction

endpackage

// File: rtl/mtap_fsm.sv
module mtap_fsm
  import mtap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

endmodule

// File: rtl/mtap_ir.sv
module mtap_ir
  import mtap_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  tap_state_e       state,
  input  logic             tdi,
  output logic [IR_W-1:0]  ir_sh,
  output logic [IR_W-1:0]  ir_cur
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= '0;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE_PAT;
    end else if (state == ST_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_cur <= OP_IDCODE;
    end else if (state == ST_RESET) begin
      ir_cur <= OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ir_cur <= ir_sh;
    end
  end

endmodule

// File: rtl/mtap_dr.sv
module mtap_dr
  import mtap_pkg::*;
#(
  parameter int          CHAIN_W = 63,
  parameter int          ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = '0
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  logic [IR_W-1:0]    ir_cur,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] pin_sample,
  output logic               dr_bit,
  output logic [CHAIN_W-1:0] bsr_out
);

  localparam int N_REGS = 3;
  localparam int SEL_BYP = 0;
  localparam int SEL_ID  = 1;
  localparam int SEL_BSR = 2;

  logic [N_REGS-1:0]  sel;
  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [CHAIN_W-1:0] bsr_q;
  logic [N_REGS-1:0]  lsb;

  always_comb begin
    sel          = '0;
    sel[SEL_ID]  = (ir_cur == OP_IDCODE);
    sel[SEL_BSR] = op_uses_chain(ir_cur);
    sel[SEL_BYP] = !sel[SEL_ID] && !sel[SEL_BSR];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else if (state == ST_CAP_DR) begin
      if (sel[SEL_BYP]) byp_q <= 1'b0;
      if (sel[SEL_ID])  id_q  <= ID_CODE;
      if (sel[SEL_BSR]) bsr_q <= pin_sample;
    end else if (state == ST_SH_DR) begin
      if (sel[SEL_BYP]) byp_q <= tdi;
      if (sel[SEL_ID])  id_q  <= {tdi, id_q[ID_W-1:1]};
      if (sel[SEL_BSR]) bsr_q <= {tdi, bsr_q[CHAIN_W-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                               bsr_out <= '0;
    else if (state == ST_UPD_DR && sel[SEL_BSR]) bsr_out <= bsr_q;
  end

  assign lsb[SEL_BYP] = byp_q;
  assign lsb[SEL_ID]  = id_q[0];
  assign lsb[SEL_BSR] = bsr_q[0];

  always_comb begin
    dr_bit = 1'b0;
    for (int i = 0; i < N_REGS; i++) begin
      if (sel[i]) dr_bit = lsb[i];
    end
  end

endmodule

// File: rtl/mem_tap_ctrl.sv
module mem_tap_ctrl
  import mtap_pkg::*;
#(
  parameter int          CHAIN_W = 63,
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_CODE = 32'h0B56_E0A3
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [CHAIN_W-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_en,
  output logic [CHAIN_W-1:0] bsr_out,
  output logic               dq_hiz,
  output logic               extest_drive
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_cur;
  logic            dr_bit;
  logic            shifting;

  mtap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  mtap_ir u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_sh  (ir_sh),
    .ir_cur (ir_cur)
  );

  mtap_dr #(
    .CHAIN_W (CHAIN_W),
    .ID_W    (ID_W),
    .ID_CODE (ID_CODE[ID_W-1:0])
  ) u_dr (
    .tck        (tck),
    .trst_n     (trst_n),
    .state      (state),
    .ir_cur     (ir_cur),
    .tdi        (tdi),
    .pin_sample (pin_sample),
    .dr_bit     (dr_bit),
    .bsr_out    (bsr_out)
  );

  assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shifting;
      if (state == ST_SH_IR)      tdo <= ir_sh[0];
      else if (state == ST_SH_DR) tdo <= dr_bit;
      else                        tdo <= 1'b0;
    end
  end

  assign dq_hiz       = (ir_cur == OP_SAMPZ);
  assign extest_drive = (ir_cur == OP_EXTEST);

endmodule

// File: rtl/mtap_chk.sv
module mtap_chk
  import mtap_pkg::*;
#(
  parameter int CHAIN_W = 63
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_sh,
  input logic [IR_W-1:0]    ir_cur,
  input logic               tdo,
  input logic               tdo_en,
  input logic [CHAIN_W-1:0] bsr_out,
  input logic               dq_hiz,
  input logic               extest_drive
);

  // R10: output enable follows the shift states, seen one half period later
  a_r10_tdo_en_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (state == ST_SH_DR || state == ST_SH_IR));

  // R10: idle output is low
  a_r10_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

  // R2: capture pattern lands in the instruction shift stage
  a_r2_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_CAP_IR |=> ir_sh == IR_CAPTURE_PAT);

  // R3: held-high mode select keeps the controller in reset
  a_r3_tms_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && tms) |=> state == ST_RESET);

  // R3: reset state leaves IDCODE as the instruction
  a_r3_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_RESET |-> ir_cur == OP_IDCODE);

  // R7 / R8: the two pad controls never overlap
  a_r7_hiz_vs_drive: assert property (@(posedge tck) disable iff (!trst_n)
    !(dq_hiz && extest_drive));

  // R9: held boundary data moves only during Update-DR
  a_r9_bsr_hold: assert property (@(posedge tck) disable iff (!trst_n)
    state != ST_UPD_DR |-> $stable(bsr_out));

endmodule

bind mem_tap_ctrl mtap_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .tck          (tck),
  .trst_n       (trst_n),
  .tms          (tms),
  .state        (state),
  .ir_sh        (ir_sh),
  .ir_cur       (ir_cur),
  .tdo          (tdo),
  .tdo_en       (tdo_en),
  .bsr_out      (bsr_out),
  .dq_hiz       (dq_hiz),
  .extest_drive (extest_drive)
);

// File: tb/mem_tap_ctrl_tb.sv
module mem_tap_ctrl_tb;

  localparam int          TCK_PERIOD = 20;
  localparam int          CW = 63;
  localparam logic [31:0] IDV = 32'h0B56_E0A3;

  localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3,  M_SHD = 4,  M_E1D = 5;
  localparam int M_PDR = 6,  M_E2D = 7,  M_UDR = 8,  M_SIR = 9,  M_CIR = 10, M_SHI = 11;
  localparam int M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [CW-1:0] pins = '0;
  logic          tdo, tdo_en, dq_hiz, extest_drive;
  logic [CW-1:0] bsr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model
  int            ms;
  logic [2:0]    m_irs, m_ir;
  bit            mq[$];
  logic [CW-1:0] m_bsr;
  logic          m_tdo, m_ten;

  mem_tap_ctrl #(.CHAIN_W(CW), .ID_W(32), .ID_CODE(IDV)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_sample(pins),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_out(bsr_out), .dq_hiz(dq_hiz),
    .extest_drive(extest_drive)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  function automatic int nxt(input int s, input logic m);
    case (s)
      M_TLR: return m ? M_TLR : M_RTI;
      M_RTI: return m ? M_SDR : M_RTI;
      M_SDR: return m ? M_SIR : M_CDR;
      M_CDR, M_SHD: return m ? M_E1D : M_SHD;
      M_E1D: return m ? M_UDR : M_PDR;
      M_PDR: return m ? M_E2D : M_PDR;
      M_E2D: return m ? M_UDR : M_SHD;
      M_UDR, M_UIR: return m ? M_SDR : M_RTI;
      M_SIR: return m ? M_TLR : M_CIR;
      M_CIR, M_SHI: return m ? M_E1I : M_SHI;
      M_E1I: return m ? M_UIR : M_PIR;
      M_PIR: return m ? M_E2I : M_PIR;
      M_E2I: return m ? M_UIR : M_SHI;
      default: return M_TLR;
    endcase
  endfunction

  function automatic bit chain_op(input logic [2:0] op);
    return op == 3'b000 || op == 3'b010 || op == 3'b100;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    ms = M_TLR; m_irs = 3'b000; m_ir = 3'b001; mq.delete();
    m_bsr = '0; m_tdo = 1'b0; m_ten = 1'b0;
  endtask

  task automatic model_rise();
    case (ms)
      M_CIR: m_irs = 3'b001;
      M_SHI: m_irs = {tdi, m_irs[2:1]};
      M_CDR: begin
        mq.delete();
        if (m_ir == 3'b001) for (int i = 0; i < 32; i++) mq.push_back(IDV[i]);
        else if (chain_op(m_ir)) for (int i = 0; i < CW; i++) mq.push_back(pins[i]);
        else mq.push_back(1'b0);
      end
      M_SHD: begin
        mq.push_back(tdi);
        void'(mq.pop_front());
      end
      default: ;
    endcase
    ms = nxt(ms, tms);
  endtask

  task automatic model_fall();
    if (ms == M_TLR) m_ir = 3'b001;
    else if (ms == M_UIR) m_ir = m_irs;
    else if (ms == M_UDR && chain_op(m_ir))
      for (int i = 0; i < CW; i++) m_bsr[i] = mq[i];
    m_ten = (ms == M_SHI) || (ms == M_SHD);
    m_tdo = (ms == M_SHI) ? m_irs[0] : (ms == M_SHD) ? mq[0] : 1'b0;
  endtask

  task automatic compare_all();
    chk("R1,R10 tdo_en", {63'd0, tdo_en}, {63'd0, m_ten});
    chk("R10 tdo", {63'd0, tdo}, {63'd0, m_tdo});
    chk("R7 dq_hiz", {63'd0, dq_hiz}, {63'd0, (m_ir == 3'b010)});
    chk("R8 extest_drive", {63'd0, extest_drive}, {63'd0, (m_ir == 3'b000)});
    chk("R9 bsr_out", {1'b0, bsr_out}, {1'b0, m_bsr});
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    model_rise();
    @(negedge tck);
    model_fall();
    #2;
    compare_all();
  endtask

  // from Run-Test/Idle back to Run-Test/Idle; returns bits seen on tdo
  task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      seen[i] = tdo;
      step(i == 2, code[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      step(i == len - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0]  irseen;
    logic [63:0] dout;
    logic [62:0] pre;
    model_reset();
    repeat (3) @(negedge tck);
    #2;
    // R3: reset state
    chk("R3 reset tdo_en", {63'd0, tdo_en}, 64'd0);
    chk("R3 reset dq_hiz", {63'd0, dq_hiz}, 64'd0);
    chk("R3 reset extest", {63'd0, extest_drive}, 64'd0);
    chk("R9 reset bsr_out", {1'b0, bsr_out}, 64'd0);
    trst_n = 1'b1;
    step(1, 0); step(0, 0);

    // R4: IDCODE is current after reset
    scan_dr(32, 64'hFFFF_FFFF, dout);
    chk("R4 idcode after reset", dout, {32'd0, IDV});

    // R5: bypass, one stage delay, captured 0 first
    load_ir(3'b111, irseen);
    chk("R2 ir capture pattern", {61'd0, irseen}, 64'd1);
    scan_dr(8, 64'hB5, dout);
    chk("R5 bypass delay", dout[7:0], {56'd0, 8'h6A});

    // R5: reserved code acts as bypass, no pad control
    load_ir(3'b101, irseen);
    chk("R5 reserved hiz", {63'd0, dq_hiz}, 64'd0);
    chk("R5 reserved extest", {63'd0, extest_drive}, 64'd0);
    scan_dr(6, 64'h2D, dout);
    chk("R5 reserved bypass delay", dout[5:0], {58'd0, 6'h1A});

    // R6/R9: SAMPLE captures pins, preloads chain
    pins = 63'h2A5A_1234_C3F0_0F1E;
    pre  = 63'h5C3E_0001_7FFE_9A81;
    load_ir(3'b100, irseen);
    scan_dr(CW, {1'b0, pre}, dout);
    chk("R6 sample capture", dout, {1'b0, 63'h2A5A_1234_C3F0_0F1E});
    chk("R9 preload to bsr_out", {1'b0, bsr_out}, {1'b0, pre});
    chk("R6 sample no hiz", {63'd0, dq_hiz}, 64'd0);

    // R8: EXTEST drives held data, capture still works
    pins = 63'h1111_2222_3333_4444;
    load_ir(3'b000, irseen);
    chk("R8 extest asserted", {63'd0, extest_drive}, 64'd1);
    chk("R8 bsr_out held", {1'b0, bsr_out}, {1'b0, pre});
    scan_dr(CW, 64'h0, dout);
    chk("R8 extest capture", dout, {1'b0, 63'h1111_2222_3333_4444});
    chk("R9 bsr_out zero update", {1'b0, bsr_out}, 64'd0);

    // R7: SAMPLE-Z
    load_ir(3'b010, irseen);
    chk("R7 hiz asserted", {63'd0, dq_hiz}, 64'd1);
    chk("R7 no extest", {63'd0, extest_drive}, 64'd0);

    // R3: five TMS-high edges from Shift-DR return to reset and IDCODE
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R3 tms reset drops hiz", {63'd0, dq_hiz}, 64'd0);
    step(0, 0);
    scan_dr(32, 64'h0, dout);
    chk("R3 idcode after tms reset", dout, {32'd0, IDV});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule